// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, in single or double precision, and turns the result into a 2-bit condition code. It writes that code into one of four 2-bit fields of a 64-bit floating-point status word and leaves every other bit as it was. The execution pipeline presents an operation code, a field selector, the two operands and the current status word together with a valid strobe. One clock later the unit returns the updated status word with a done strobe.

Two kinds of compare are supported. A quiet compare reports an unordered result when either operand is a NaN. A signaling compare raises an invalid-operation exception in that case. The two quad-precision compare codes are recognised but not carried out; they raise a separate "other" exception. Any other operation code in the group raises an unimplemented indication. Whenever an exception is raised, the status word passes through unchanged.

Top module: `fpcmp_unit`

## Requirements
- R1: For an ordered compare, the code is 0 when the operands are equal, 1 when A is less than B, and 2 when A is greater than B. Operation code 0x51 is a quiet single compare and 0x52 is a quiet double compare. A single operand is taken from bits [31:0], and bits [63:32] of that operand have no effect.
- R2: A quiet compare (0x51 or 0x52) gives code 3 when either operand is a NaN. A NaN is an exponent of all ones with a nonzero fraction. An infinity is not a NaN and compares in the ordered way.
- R3: Positive zero and negative zero compare as equal. Ordering is by sign first and then by magnitude. When both operands are negative, the magnitude order is reversed.
- R4: Selector 0 writes the code to status bits [11:10]. Selector n of 1 to 3 writes it to bits [2n+31:2n+30], that is [33:32], [35:34] or [37:36].
- R5: All status bits outside the selected field are copied unchanged from status_in.
- R6: A signaling compare (0x54 single, 0x55 double) with a NaN operand sets exc_invalid and passes status_in through unchanged. With no NaN operand it writes the code in the same way as R1.
- R7: Operation codes 0x53 and 0x56 set exc_other and pass status_in through unchanged.
- R8: Any other operation code sets exc_unimpl and passes status_in through unchanged.
- R9: For each cycle in which in_valid is high, done is high in the following cycle, together with the result and any exception flag. At most one exception flag is high at a time. In any cycle after one without in_valid, done and all flags are low and status_out keeps its previous value.
- R10: A synchronous active-high reset clears status_out, done and all exception flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_opcode | input | 9 | Compare operation code |
| in_sel | input | 2 | Condition field selector |
| op_a | input | 64 | First operand (single in [31:0]) |
| op_b | input | 64 | Second operand (single in [31:0]) |
| status_in | input | 64 | Current status word |
| status_out | output | 64 | Updated status word |
| done | output | 1 | Result strobe, one cycle after in_valid |
| exc_invalid | output | 1 | Signaling compare met a NaN |
| exc_other | output | 1 | Quad compare requested |
| exc_unimpl | output | 1 | Unknown operation code |

## Verification
The assertions assume that in_valid is never raised during reset. They also assume that status_in, in_opcode and the operands are stable and known in every cycle that carries in_valid, because several properties compare status_out with the status_in of the cycle before. The bench meets these assumptions by holding in_valid low throughout reset and by changing inputs only on falling edges. Operands are drawn from a pool of zeros, infinities, NaNs, ones, denormals and random bit patterns. For single-precision requests the upper 32 operand bits are filled with random values, so the bench also exercises the rule that those bits have no effect.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int OPC_W   = 9;
    localparam int SR_W    = 64;
    localparam int OPND_W  = 64;
    localparam int SEL_W   = 2;
    localparam int N_FIELD = 1 << SEL_W;
    localparam int MAG_W   = OPND_W - 1;

    localparam logic [OPC_W-1:0] OPC_QS  = 9'h051;
    localparam logic [OPC_W-1:0] OPC_QD  = 9'h052;
    localparam logic [OPC_W-1:0] OPC_QQ  = 9'h053;
    localparam logic [OPC_W-1:0] OPC_SS  = 9'h054;
    localparam logic [OPC_W-1:0] OPC_SD  = 9'h055;
    localparam logic [OPC_W-1:0] OPC_SQ  = 9'h056;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_e;

    typedef enum logic [2:0] {
        K_QUIET_S,
        K_QUIET_D,
        K_SIG_S,
        K_SIG_D,
        K_QUAD,
        K_BAD
    } kind_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef struct packed {
        logic [SR_W-1:0] status;
        logic            done;
        logic            exc_invalid;
        logic            exc_other;
        logic            exc_unimpl;
    } result_t;

    function automatic kind_e decode_op(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_QS:         return K_QUIET_S;
            OPC_QD:         return K_QUIET_D;
            OPC_SS:         return K_SIG_S;
            OPC_SD:         return K_SIG_D;
            OPC_QQ, OPC_SQ: return K_QUAD;
            default:        return K_BAD;
        endcase
    endfunction

    function automatic logic is_double(input kind_e k);
        return (k == K_QUIET_D) || (k == K_SIG_D);
    endfunction

    function automatic int field_lo(input int idx);
        return (idx == 0) ? 10 : (2 * idx + 30);
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] bits,
    output opnd_t                 info
);
    localparam int TOP = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = bits[TOP-1 -: EXP_W];
    assign frac_f = bits[FRAC_W-1:0];

    always_comb begin
        info         = '0;
        info.sign    = bits[TOP];
        info.is_nan  = (&exp_f) && (|frac_f);
        info.is_zero = ~|bits[TOP-1:0];
        info.mag     = MAG_W'(bits[TOP-1:0]);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output fcc_e  rel,
    output logic  unordered
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt    = a.mag < b.mag;
    assign mag_eq    = a.mag == b.mag;
    assign unordered = a.is_nan | b.is_nan;

    always_comb begin
        if (unordered) begin
            rel = FCC_UN;
        end else if (a.is_zero && b.is_zero) begin
            rel = FCC_EQ;
        end else if (a.sign != b.sign) begin
            rel = a.sign ? FCC_LT : FCC_GT;
        end else if (mag_eq) begin
            rel = FCC_EQ;
        end else if (mag_lt) begin
            rel = a.sign ? FCC_GT : FCC_LT;
        end else begin
            rel = a.sign ? FCC_LT : FCC_GT;
        end
    end
endmodule

// File: rtl/fpcmp_field_insert.sv
module fpcmp_field_insert
    import fpcmp_pkg::*;
(
    input  logic [SR_W-1:0]  status_in,
    input  logic [SEL_W-1:0] sel,
    input  fcc_e             code,
    output logic [SR_W-1:0]  status_out
);
    logic [N_FIELD-1:0][SR_W-1:0] mask_v;
    logic [N_FIELD-1:0][SR_W-1:0] data_v;

    for (genvar g = 0; g < N_FIELD; g++) begin : g_field
        localparam int LO = field_lo(g);
        assign mask_v[g] = SR_W'(2'b11) << LO;
        assign data_v[g] = SR_W'(code) << LO;
    end

    always_comb begin
        status_out = (status_in & ~mask_v[sel]) | data_v[sel];
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [OPND_W-1:0] op_a,
    input  logic [OPND_W-1:0] op_b,
    input  logic [SR_W-1:0]   status_in,
    output logic [SR_W-1:0]   status_out,
    output logic              done,
    output logic              exc_invalid,
    output logic              exc_other,
    output logic              exc_unimpl
);
    kind_e       kind;
    opnd_t [1:0] sgl_info;
    opnd_t [1:0] dbl_info;
    opnd_t [1:0] sel_info;
    fcc_e        rel;
    logic        unordered;
    logic [SR_W-1:0] ins_status;
    result_t     res_d;
    result_t     res_q;

    assign kind = decode_op(in_opcode);

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        logic [OPND_W-1:0] raw;
        assign raw = (k == 0) ? op_a : op_b;

        fpcmp_classify #(.EXP_W(8), .FRAC_W(23)) u_sgl (
            .bits (raw[31:0]),
            .info (sgl_info[k])
        );
        fpcmp_classify #(.EXP_W(11), .FRAC_W(52)) u_dbl (
            .bits (raw),
            .info (dbl_info[k])
        );
        assign sel_info[k] = is_double(kind) ? dbl_info[k] : sgl_info[k];
    end

    fpcmp_order u_order (
        .a         (sel_info[0]),
        .b         (sel_info[1]),
        .rel       (rel),
        .unordered (unordered)
    );

    fpcmp_field_insert u_insert (
        .status_in  (status_in),
        .sel        (in_sel),
        .code       (rel),
        .status_out (ins_status)
    );

    always_comb begin
        res_d        = res_q;
        res_d.done        = 1'b0;
        res_d.exc_invalid = 1'b0;
        res_d.exc_other   = 1'b0;
        res_d.exc_unimpl  = 1'b0;
        if (in_valid) begin
            res_d.done   = 1'b1;
            res_d.status = status_in;
            unique case (kind)
                K_QUIET_S, K_QUIET_D: res_d.status = ins_status;
                K_SIG_S, K_SIG_D: begin
                    if (unordered) res_d.exc_invalid = 1'b1;
                    else           res_d.status      = ins_status;
                end
                K_QUAD:  res_d.exc_other  = 1'b1;
                default: res_d.exc_unimpl = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign status_out  = res_q.status;
    assign done        = res_q.done;
    assign exc_invalid = res_q.exc_invalid;
    assign exc_other   = res_q.exc_other;
    assign exc_unimpl  = res_q.exc_unimpl;
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk
    import fpcmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPC_W-1:0]  in_opcode,
    input logic [SR_W-1:0]   status_in,
    input logic [SR_W-1:0]   status_out,
    input logic              done,
    input logic              exc_invalid,
    input logic              exc_other,
    input logic              exc_unimpl
);
    localparam logic [SR_W-1:0] ANY_FIELD = SR_W'(64'h0000_003F_0000_0C00);

    logic any_exc;
    assign any_exc = exc_invalid | exc_other | exc_unimpl;

    p_done_after_valid_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!done && !any_exc));

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status_out));

    p_one_flag_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_invalid, exc_other, exc_unimpl}));

    p_flag_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        any_exc |-> done);

    p_outside_kept_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ((status_out & ~ANY_FIELD) == ($past(status_in) & ~ANY_FIELD)));

    p_exc_passthru_r6: assert property (@(posedge clk) disable iff (rst)
        any_exc |-> (status_out == $past(status_in)));

    p_quad_other_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_opcode == OPC_QQ || in_opcode == OPC_SQ)) |=> exc_other);

    p_quiet_no_exc_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_opcode == OPC_QS || in_opcode == OPC_QD)) |=> !any_exc);
endmodule

bind fpcmp_unit fpcmp_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .status_in   (status_in),
    .status_out  (status_out),
    .done        (done),
    .exc_invalid (exc_invalid),
    .exc_other   (exc_other),
    .exc_unimpl  (exc_unimpl)
);

// File: tb/fpcmp_unit_tb_top.sv
module fpcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [8:0]  in_opcode;
    logic [1:0]  in_sel;
    logic [63:0] op_a, op_b, status_in;
    logic [63:0] status_out;
    logic        done, exc_invalid, exc_other, exc_unimpl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] e_status = '0;
    logic        e_done = 0, e_inv = 0, e_oth = 0, e_unimp = 0;
    string       e_tag = "R10";

    always #2 clk = ~clk;

    fpcmp_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_sel(in_sel), .op_a(op_a), .op_b(op_b), .status_in(status_in),
        .status_out(status_out), .done(done), .exc_invalid(exc_invalid),
        .exc_other(exc_other), .exc_unimpl(exc_unimpl)
    );

    function automatic bit nan_of(bit dbl, logic [63:0] v);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic longint key_of(bit dbl, logic [63:0] v);
        longint m;
        bit     s;
        m = dbl ? longint'(v[62:0]) : longint'(v[30:0]);
        s = dbl ? v[63] : v[31];
        if (m == 0) return 0;
        return s ? -m : m;
    endfunction

    task automatic check_now();
        checks++;
        if ({status_out, done, exc_invalid, exc_other, exc_unimpl} !==
            {e_status, e_done, e_inv, e_oth, e_unimp}) begin
            errors++;
            $display("FAIL %s: got st=%h d=%b inv=%b oth=%b un=%b exp st=%h d=%b inv=%b oth=%b un=%b",
                     e_tag, status_out, done, exc_invalid, exc_other, exc_unimpl,
                     e_status, e_done, e_inv, e_oth, e_unimp);
        end
    endtask

    // One cycle: check the previous result, then apply new inputs and predict.
    task automatic step(bit v, logic [8:0] opc, logic [1:0] sel,
                        logic [63:0] a, logic [63:0] b, logic [63:0] st, string tag);
        int  lo;
        bit  dbl, nan, sig;
        int  code;
        longint ka, kb;
        @(negedge clk);
        check_now();
        in_valid = v; in_opcode = opc; in_sel = sel; op_a = a; op_b = b; status_in = st;
        e_done = v; e_inv = 0; e_oth = 0; e_unimp = 0;
        e_tag = (tag.len() != 0) ? tag : "R9";
        if (v) begin
            e_status = st;
            if (opc == 9'h053 || opc == 9'h056) begin
                e_oth = 1;
                if (tag.len() == 0) e_tag = "R7";
            end else if (opc == 9'h051 || opc == 9'h052 || opc == 9'h054 || opc == 9'h055) begin
                dbl = (opc == 9'h052 || opc == 9'h055);
                sig = (opc == 9'h054 || opc == 9'h055);
                nan = nan_of(dbl, a) || nan_of(dbl, b);
                ka = key_of(dbl, a);
                kb = key_of(dbl, b);
                code = nan ? 3 : (ka < kb) ? 1 : (ka > kb) ? 2 : 0;
                lo = (sel == 0) ? 10 : 30 + 2 * int'(sel);
                if (sig && nan) begin
                    e_inv = 1;
                    if (tag.len() == 0) e_tag = "R6";
                end else begin
                    e_status[lo +: 2] = code[1:0];
                    if (tag.len() == 0) e_tag = nan ? "R2" : "R1";
                end
            end else begin
                e_unimp = 1;
                if (tag.len() == 0) e_tag = "R8";
            end
        end
    endtask

    function automatic logic [63:0] pick(bit dbl, int k);
        logic [63:0] r;
        r = {$urandom, $urandom};
        case (k)
            0: return dbl ? 64'h0 : {r[63:32], 32'h0};
            1: return dbl ? 64'h8000_0000_0000_0000 : {r[63:32], 32'h8000_0000};
            2: return dbl ? 64'h3FF0_0000_0000_0000 : {r[63:32], 32'h3F80_0000};
            3: return dbl ? 64'hBFF0_0000_0000_0000 : {r[63:32], 32'hBF80_0000};
            4: return dbl ? 64'h7FF0_0000_0000_0000 : {r[63:32], 32'h7F80_0000};
            5: return dbl ? 64'hFFF0_0000_0000_0000 : {r[63:32], 32'hFF80_0000};
            6: return dbl ? 64'h7FF8_0000_0000_0000 : {r[63:32], 32'h7FC0_0000};
            7: return dbl ? 64'hFFF0_0000_0000_0001 : {r[63:32], 32'hFF80_0001};
            8: return dbl ? 64'h0000_0000_0000_0003 : {r[63:32], 32'h8000_0002};
            default: return r;
        endcase
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got running exp finished");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    localparam logic [63:0] ONE_S = 64'h3F80_0000;
    localparam logic [63:0] TWO_S = 64'h4000_0000;
    localparam logic [63:0] NONE  = 64'h0;

    initial begin : main
        logic [8:0] opcs [0:9];
        opcs = '{9'h051, 9'h052, 9'h054, 9'h055, 9'h053, 9'h056,
                 9'h050, 9'h057, 9'h1FF, 9'h000};
        rst = 1; in_valid = 0; in_opcode = 0; in_sel = 0;
        op_a = 0; op_b = 0; status_in = '1;
        // R10: reset clears everything
        repeat (3) step(0, 9'h051, 0, NONE, NONE, '1, "R10");
        // valid during reset is not driven; release reset
        @(negedge clk); check_now(); rst = 0; e_tag = "R10";
        // R1 ordered codes, single and double
        step(1, 9'h051, 0, ONE_S, ONE_S, 64'h0, "R1");
        step(1, 9'h051, 0, ONE_S, TWO_S, 64'h0, "R1");
        step(1, 9'h051, 0, TWO_S, ONE_S, 64'h0, "R1");
        step(1, 9'h052, 1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h0, "R1");
        step(1, 9'h051, 0, {32'hFFFF_FFFF, ONE_S[31:0]}, ONE_S, 64'h0, "R1");
        // R2 quiet NaN and infinity
        step(1, 9'h051, 2, 64'h7FC0_0000, ONE_S, 64'h0, "R2");
        step(1, 9'h052, 3, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 64'h0, "R2");
        step(1, 9'h051, 0, 64'h7F80_0000, ONE_S, 64'h0, "R2");
        // R3 zeros and negatives
        step(1, 9'h051, 0, 64'h8000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        step(1, 9'h052, 0, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        step(1, 9'h051, 0, 64'hC000_0000, 64'hBF80_0000, 64'h0, "R3");
        step(1, 9'h052, 1, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h0, "R3");
        step(1, 9'h051, 0, 64'h8000_0000, 64'h0000_0001, 64'h0, "R3");
        // R4 / R5 each field with patterned status
        for (int s = 0; s < 4; s++) begin
            step(1, 9'h051, 2'(s), ONE_S, TWO_S, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
            step(1, 9'h051, 2'(s), ONE_S, TWO_S, 64'hA5A5_5A5A_C3C3_3C3C, "R5");
        end
        // R6 signaling variants
        step(1, 9'h054, 1, 64'h7FC0_0000, ONE_S, 64'h1234_5678_9ABC_DEF0, "R6");
        step(1, 9'h055, 2, 64'h0, 64'hFFF8_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, "R6");
        step(1, 9'h054, 3, TWO_S, ONE_S, 64'h0, "R6");
        // R7 / R8
        step(1, 9'h053, 0, ONE_S, TWO_S, 64'hDEAD_BEEF_0000_FFFF, "R7");
        step(1, 9'h056, 1, ONE_S, TWO_S, 64'hDEAD_BEEF_0000_FFFF, "R7");
        step(1, 9'h050, 0, ONE_S, TWO_S, 64'h0F0F_0F0F_0F0F_0F0F, "R8");
        step(1, 9'h1FF, 0, ONE_S, TWO_S, 64'h0F0F_0F0F_0F0F_0F0F, "R8");
        // R9 hold on idle
        step(0, 9'h051, 0, ONE_S, TWO_S, 64'h0, "R9");
        step(0, 9'h051, 3, TWO_S, ONE_S, 64'hFFFF, "R9");
        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [8:0] o;
            bit d;
            o = opcs[$urandom % 10];
            d = (o == 9'h052 || o == 9'h055);
            step(($urandom % 5) != 0, o, 2'($urandom), pick(d, int'($urandom % 10)),
                 pick(d, int'($urandom % 10)), {$urandom, $urandom}, "");
        end
        step(0, 9'h000, 0, NONE, NONE, NONE, "R9");
        @(negedge clk);
        check_now();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule